// File: doc/BRIEF.md
# Countdown Timer with Auto-Reload

This block is a down-counter that signals when its count runs out. Each cycle in which the shared tick enable is high, the counter steps down by one. The tick enable is the same one that advances the time base. When a tick takes the count from one to zero, the block emits a single-cycle expiry pulse. That pulse is meant to set the decrementer bit in a separate status register. Interrupt gating happens outside the block.

Software loads the counter and a separate reload register over a simple register-bus write strobe. A control-register unit supplies the auto-reload enable. When this enable is high at expiry, the counter takes the reload value instead of zero, and periodic events follow without further writes. When it is low, the counter stops at zero and stays silent until software writes it again.

Top module: `countdown_timer`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, cnt_o and reload_o read zero and expire_o is low.
- R2: With no counter write, a tick while cnt_o is above one lowers cnt_o by exactly one at the next edge. With no tick and no write, cnt_o holds.
- R3: A tick without a counter write while cnt_o equals one raises expire_o for exactly the one cycle after that edge. expire_o is never high at any other time.
- R4: With auto_reload_i low at expiry, cnt_o becomes zero and then holds at zero under further ticks, with no further expiry pulses.
- R5: With auto_reload_i high at expiry, cnt_o is loaded with the reload register value held before that edge (not zero).
- R6: A counter write (cnt_wr_i high) loads wr_data_i at the next edge and takes priority over a tick in the same cycle. No expiry pulse follows, even when cnt_o was one.
- R7: Writing zero to the counter gives no expiry pulse. Ticks on a zero count give no pulse and do not reload, even with auto_reload_i high.
- R8: reload_wr_i loads wr_data_i into the reload register without affecting cnt_o. If an expiry falls in the same cycle, the counter takes the old reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable shared with the time base |
| cnt_wr_i | input | 1 | Write strobe for the counter |
| reload_wr_i | input | 1 | Write strobe for the reload register |
| wr_data_i | input | W | Write data for either register |
| auto_reload_i | input | 1 | Reload at expiry when high; stop at zero when low |
| cnt_o | output | W | Current count |
| reload_o | output | W | Reload register contents |
| expire_o | output | 1 | One-cycle expiry pulse to the status register |

## Verification
Two things can land in the same cycle as a final tick. One is a software write to the counter, where the write must win and suppress the pulse. The other is a reload-register write, where the counter must take the old reload value while the register takes the new one. The vector table drives each collision with the count parked at one. It then judges the count, the reload value and the pulse in the cycle right after the edge. Further rows check that the count stays at zero after a write of zero, and that back-to-back expiries occur when the reload value is one.

// File: rtl/countdown_pkg.sv
`timescale 1ns/1ps
package countdown_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_SWLOAD = 2'd1,
    ACT_STEP   = 2'd2,
    ACT_EXPIRE = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/countdown_reload.sv
`timescale 1ns/1ps
module countdown_reload #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_o <= '0;
    else if (wr_i) val_o <= data_i;
  end
endmodule

// File: rtl/countdown_ctrl.sv
`timescale 1ns/1ps
module countdown_ctrl
  import countdown_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_i,
  output cnt_act_e     act_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    act_o = ACT_HOLD;
    if (cnt_wr_i)                  act_o = ACT_SWLOAD;  // write beats tick
    else if (tick_i && cnt_i == ONE) act_o = ACT_EXPIRE;
    else if (tick_i && cnt_i != '0)  act_o = ACT_STEP;
  end
endmodule

// File: rtl/countdown_counter.sv
`timescale 1ns/1ps
module countdown_counter
  import countdown_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_act_e     act_i,
  input  logic         auto_reload_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;

  always_comb begin
    unique case (act_i)
      ACT_SWLOAD: cnt_d = wr_data_i;
      ACT_STEP:   cnt_d = cnt_o - ONE;
      ACT_EXPIRE: cnt_d = auto_reload_i ? reload_i : '0;
      default:    cnt_d = cnt_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      expire_o <= 1'b0;
    end else begin
      cnt_o    <= cnt_d;
      expire_o <= (act_i == ACT_EXPIRE);
    end
  end
endmodule

// File: rtl/countdown_timer.sv
`timescale 1ns/1ps
module countdown_timer
  import countdown_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic         reload_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         auto_reload_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] reload_o,
  output logic         expire_o
);
  cnt_act_e act;

  countdown_reload #(.W(W)) u_reload (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reload_wr_i),
    .data_i (wr_data_i),
    .val_o  (reload_o)
  );

  countdown_ctrl #(.W(W)) u_ctrl (
    .tick_i   (tick_i),
    .cnt_wr_i (cnt_wr_i),
    .cnt_i    (cnt_o),
    .act_o    (act)
  );

  countdown_counter #(.W(W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .act_i         (act),
    .auto_reload_i (auto_reload_i),
    .wr_data_i     (wr_data_i),
    .reload_i      (reload_o),
    .cnt_o         (cnt_o),
    .expire_o      (expire_o)
  );
endmodule

// File: rtl/countdown_timer_chk.sv
`timescale 1ns/1ps
module countdown_timer_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         cnt_wr_i,
  input logic         reload_wr_i,
  input logic [W-1:0] wr_data_i,
  input logic         auto_reload_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] reload_o,
  input logic         expire_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && tick_i && cnt_o > ONE) |=> cnt_o == $past(cnt_o) - ONE);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && !tick_i) |=> $stable(cnt_o));

  p_pulse_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_i && !cnt_wr_i && cnt_o == ONE));

  p_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && tick_i && cnt_o == ONE && !auto_reload_i) |=> cnt_o == '0);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && tick_i && cnt_o == ONE && auto_reload_i) |=> cnt_o == $past(reload_o));

  p_wr_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_o == $past(wr_data_i) && !expire_o));

  p_zero_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && cnt_o == '0) |=> (cnt_o == '0 && !expire_o));

  p_reload_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_wr_i |=> reload_o == $past(wr_data_i));
endmodule

bind countdown_timer countdown_timer_chk #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .cnt_wr_i      (cnt_wr_i),
  .reload_wr_i   (reload_wr_i),
  .wr_data_i     (wr_data_i),
  .auto_reload_i (auto_reload_i),
  .cnt_o         (cnt_o),
  .reload_o      (reload_o),
  .expire_o      (expire_o)
);

// File: tb/countdown_timer_bench.sv
`timescale 1ns/1ps
module countdown_timer_bench;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   req;
    logic         cw;
    logic         rw;
    logic         tk;
    logic         ar;
    logic [W-1:0] d;
    logic [W-1:0] ec;
    logic [W-1:0] er;
    logic         ee;
  } vec_t;

  // req, cnt_wr, reload_wr, tick, auto, data, exp cnt, exp reload, exp pulse
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 32'd3, 32'd0, 32'd3, 1'b0}, // R8 reload write only
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 32'd2, 32'd2, 32'd3, 1'b0}, // R6 load
    '{4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd1, 32'd3, 1'b0}, // R2 step
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 32'd1, 32'd3, 1'b0}, // R2 hold
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0, 32'd3, 1'b1}, // R4 expire, stop
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0, 32'd3, 1'b0}, // R3 one cycle only
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0, 32'd3, 1'b0}, // R4 stays at zero
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 32'd1, 32'd1, 32'd3, 1'b0}, // R6
    '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd3, 32'd3, 1'b1}, // R5 reload
    '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd2, 32'd3, 1'b0}, // R5 continues
    '{4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd1, 32'd3, 1'b0}, // R2
    '{4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 32'd5, 32'd5, 32'd3, 1'b0}, // R6 write beats tick at 1
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 32'd1, 32'd1, 32'd3, 1'b0}, // R6
    '{4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 32'd7, 32'd7, 32'd3, 1'b0}, // R6 write beats tick at 1
    '{4'd7, 1'b1, 1'b0, 1'b0, 1'b1, 32'd0, 32'd0, 32'd3, 1'b0}, // R7 write zero
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd0, 32'd3, 1'b0}, // R7 no reload from zero
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 32'd1, 32'd1, 32'd3, 1'b0}, // R6
    '{4'd8, 1'b0, 1'b1, 1'b1, 1'b1, 32'd9, 32'd3, 32'd9, 1'b1}, // R8 old reload used
    '{4'd8, 1'b0, 1'b1, 1'b1, 1'b1, 32'd1, 32'd2, 32'd1, 1'b0}, // R8 no cnt effect
    '{4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd1, 32'd1, 1'b0}, // R2
    '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd1, 32'd1, 1'b1}, // R5 reload of one
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 32'd0, 32'd1, 32'd1, 1'b1}  // R3 back-to-back
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, cnt_wr = 1'b0, reload_wr = 1'b0, auto_rl = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt, rel;
  logic         expire;
  int           n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  countdown_timer #(.W(W)) u_countdown_timer (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .cnt_wr_i (cnt_wr),
    .reload_wr_i (reload_wr), .wr_data_i (wdata), .auto_reload_i (auto_rl),
    .cnt_o (cnt), .reload_o (rel), .expire_o (expire)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cw, input logic rw, input logic tk,
                       input logic ar, input logic [W-1:0] d);
    @(negedge clk);
    cnt_wr = cw; reload_wr = rw; tick = tk; auto_rl = ar; wdata = d;
    @(posedge clk);
    #2;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      summary();
    end
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1 cnt in reset", cnt, '0);
    chk("R1 reload in reset", rel, '0);
    chk("R1 pulse in reset", {31'd0, expire}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 cnt after release", cnt, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cw, VECS[i].rw, VECS[i].tk, VECS[i].ar, VECS[i].d);
      chk($sformatf("R%0d vec%0d cnt", VECS[i].req, i), cnt, VECS[i].ec);
      chk($sformatf("R%0d vec%0d reload", VECS[i].req, i), rel, VECS[i].er);
      chk($sformatf("R%0d vec%0d pulse", VECS[i].req, i), {31'd0, expire}, {31'd0, VECS[i].ee});
    end

    // R2 full-scale decrement
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R2 full-scale step", cnt, 32'hFFFF_FFFE);

    // R5 reload of zero: expire then stay quiet
    drive(1'b1, 1'b1, 1'b0, 1'b1, 32'd1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 32'd0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk("R5 zero reload pulse", {31'd0, expire}, 32'd1);
    chk("R5 zero reload cnt", cnt, '0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk("R7 no pulse at zero", {31'd0, expire}, '0);

    // R1 asynchronous reset mid-count
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'd44);
    @(negedge clk); cnt_wr = 1'b0; reload_wr = 1'b0; rst_n = 1'b0;
    #2;
    chk("R1 async cnt", cnt, '0);
    chk("R1 async reload", rel, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after re-release", cnt, '0);

    summary();
  end
endmodule